// File: doc/BRIEF.md
# Audio Converter Clock Timing Controller

This block turns a master clock into every timing signal a stereo oversampling audio converter needs. It makes a one-cycle enable at the modulator rate, which is 64fs or 32fs. It also makes a bit clock, a frame (left/right) clock for serial output when the converter is the clock master, and a one-cycle sample strobe per frame for the decimator. Every output is a registered signal in the master-clock domain. The bit clock and the frame clock are plain levels that the pad logic drives out.

A two-bit mode input sets the ratio of master clock to fs (128, 256 or 384) and sets the oversampling rate. The block samples this input only while reset is asserted, so a new mode takes effect only through a reset. The 384fs mode needs an odd-looking division by six for the bit clock. The block keeps a symmetric three-high / three-low bit-clock phase in that mode. A synchronous reset clears every divider, so all outputs line up again from a known phase.

Top module: `adc_clk_timing`

## Requirements
- R1: At every clock edge where `rst_n` is sampled low, all four outputs become 0 after that edge, and every divider returns to its start.
- R2: `mode_sel` is captured only while `rst_n` is low. Codes: 00 means 256fs with 64fs modulation, 01 means 384fs with 64fs, 10 means 256fs with 32fs, 11 means 128fs with 32fs. A change of `mode_sel` while running has no effect on any output.
- R3: `bck` has a period of 4, 6, 4 and 2 master-clock cycles for codes 00, 01, 10 and 11, so it is 64fs in every mode.
- R4: In each `bck` period, `bck` is low for the first half of the cycles and high for the second half. In code 01 this gives 3 cycles low and 3 cycles high.
- R5: `mod_en` is a one-cycle pulse every 4, 6, 8 and 4 master-clock cycles for codes 00, 01, 10 and 11.
- R6: `lrck` is low for 32 `bck` periods (left channel), then high for 32 (right channel). It changes only in the cycle in which `bck` falls.
- R7: `smp_stb` is a one-cycle pulse at the start of each left half-frame, once every 64 `bck` periods. When it is high, `bck` and `lrck` are both low.
- R8: Let t be the count of master-clock cycles after the first edge that samples `rst_n` high, with t = 0 on that edge. The outputs then show phase t. At t = 0, `mod_en` and `smp_stb` are 1, and `bck` and `lrck` are 0.
- R9: A reset applied mid-frame restarts all outputs at phase t = 0 in the newly captured mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mck | input | 1 | Master clock; every register uses its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; mode is captured while low |
| mode_sel | input | 2 | Clock ratio / oversampling mode code |
| mod_en | output | 1 | Modulator-rate clock enable pulse |
| bck | output | 1 | Bit clock level at 64fs |
| lrck | output | 1 | Frame clock at fs, low for left |
| smp_stb | output | 1 | One-cycle strobe at the start of each left half-frame |

## Verification
Each of the four mode codes runs for more than two full frames. Every cycle is compared with an arithmetic model of phase t. This separates the even divide ratios from the divide-by-six path, and it separates the modulator rate from the bit-clock rate. A run ends in the middle of a frame and the next run resets straight away, which shows whether the dividers realign or carry stale phase. Halfway through each run `mode_sel` is flipped to a different code. Only a design that ignores the input outside reset keeps matching the model.

// File: rtl/actc_pkg.sv
// Shared types and mode decoding for the audio converter clock timing block.
// Assumes the bit clock is always BCK_PER_FS times the frame rate.
package actc_pkg;

    localparam int unsigned BCK_PER_FS = 64;

    typedef enum logic [1:0] {
        MODE_256_OS64 = 2'b00,
        MODE_384_OS64 = 2'b01,
        MODE_256_OS32 = 2'b10,
        MODE_128_OS32 = 2'b11
    } actc_mode_e;

    // Master clock cycles per frame for a mode.
    function automatic int unsigned mck_per_fs(actc_mode_e m);
        case (m)
            MODE_384_OS64: return 384;
            MODE_128_OS32: return 128;
            default:       return 256;
        endcase
    endfunction

    // Modulator ticks per frame for a mode.
    function automatic int unsigned os_per_fs(actc_mode_e m);
        case (m)
            MODE_256_OS32, MODE_128_OS32: return 32;
            default:                      return 64;
        endcase
    endfunction

endpackage

// File: rtl/actc_mode_latch.sv
// Mode capture: samples the mode code while reset is held. It turns the code
// into the last count value of the bit-clock divider and of the modulator
// divider. Assumes every ratio fits in DIV_W bits.
module actc_mode_latch
    import actc_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    output logic [DIV_W-1:0] bck_last,
    output logic [DIV_W-1:0] mod_last,
    output logic [DIV_W-1:0] bck_half
);

    actc_mode_e mode_q;

    // Capture the mode only during reset; hold it while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= actc_mode_e'(mode_sel);
        end
    end

    // Derive the divider limits from the captured ratios.
    always_comb begin
        bck_last = DIV_W'(mck_per_fs(mode_q) / BCK_PER_FS - 1);
        mod_last = DIV_W'(mck_per_fs(mode_q) / os_per_fs(mode_q) - 1);
        bck_half = DIV_W'(mck_per_fs(mode_q) / BCK_PER_FS / 2);
    end

endmodule

// File: rtl/actc_mod_counter.sv
// Modulo counter: counts 0..last when adv is set, then wraps to 0.
// Assumes last does not change while counting, except across a reset.
module actc_mod_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt
);

    // Advance, or wrap after the last value; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= (cnt == last) ? '0 : cnt + W'(1);
        end
    end

endmodule

// File: rtl/adc_clk_timing.sv
// Top of the clock timing controller. A bit divider, a frame-position counter
// and a modulator divider run from the master clock. Registered output decode
// produces the bit clock, frame clock, sample strobe and modulator enable.
// Assumes FRAME_BCK is even and a mode change always comes with a reset.
module adc_clk_timing
    import actc_pkg::*;
#(
    parameter int DIV_W     = 4,
    parameter int FRAME_BCK = BCK_PER_FS
) (
    input  logic       mck,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    output logic       mod_en,
    output logic       bck,
    output logic       lrck,
    output logic       smp_stb
);

    localparam int IDX_W = $clog2(FRAME_BCK);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BCK - 1);
    localparam logic [IDX_W-1:0] IDX_RIGHT = IDX_W'(FRAME_BCK / 2);

    logic [DIV_W-1:0] bck_last;
    logic [DIV_W-1:0] mod_last;
    logic [DIV_W-1:0] bck_half;
    logic [DIV_W-1:0] bit_cnt;
    logic [DIV_W-1:0] mod_cnt;
    logic [IDX_W-1:0] frame_idx;
    logic             bit_wrap;

    actc_mode_latch #(.DIV_W(DIV_W)) u_mode (
        .clk      (mck),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .bck_last (bck_last),
        .mod_last (mod_last),
        .bck_half (bck_half)
    );

    actc_mod_counter #(.W(DIV_W)) u_bit_div (
        .clk   (mck),
        .rst_n (rst_n),
        .adv   (1'b1),
        .last  (bck_last),
        .cnt   (bit_cnt)
    );

    // One bit-clock period ends when the bit divider reaches its last count.
    assign bit_wrap = (bit_cnt == bck_last);

    actc_mod_counter #(.W(IDX_W)) u_frame_pos (
        .clk   (mck),
        .rst_n (rst_n),
        .adv   (bit_wrap),
        .last  (IDX_LAST),
        .cnt   (frame_idx)
    );

    actc_mod_counter #(.W(DIV_W)) u_mod_div (
        .clk   (mck),
        .rst_n (rst_n),
        .adv   (1'b1),
        .last  (mod_last),
        .cnt   (mod_cnt)
    );

    // Register the decoded phases so each output comes from a flop.
    always_ff @(posedge mck) begin
        if (!rst_n) begin
            bck     <= 1'b0;
            lrck    <= 1'b0;
            smp_stb <= 1'b0;
            mod_en  <= 1'b0;
        end else begin
            bck     <= (bit_cnt >= bck_half);
            lrck    <= (frame_idx >= IDX_RIGHT);
            smp_stb <= (bit_cnt == '0) && (frame_idx == '0);
            mod_en  <= (mod_cnt == '0);
        end
    end

endmodule

// File: rtl/actc_timing_chk.sv
// Checker for adc_clk_timing. It keeps its own copy of the mode from the
// ports and measures pulse and level run lengths with small counters.
module actc_timing_chk (
    input logic       mck,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       mod_en,
    input logic       bck,
    input logic       lrck,
    input logic       smp_stb
);

    logic [1:0]  m_q;
    logic [11:0] exp_half, exp_mod, exp_frame;
    logic [11:0] hi_run, lo_run, mod_gap, stb_gap;
    logic        armed, bck_d, mod_seen, stb_seen, rst_low_q;

    // Capture the mode from the ports during reset.
    always_ff @(posedge mck) begin
        if (!rst_n) m_q <= mode_sel;
    end

    // Expected half bit period, modulator gap and frame length.
    always_comb begin
        case (m_q)
            2'b01:   begin exp_half = 12'd3; exp_mod = 12'd6; end
            2'b10:   begin exp_half = 12'd2; exp_mod = 12'd8; end
            2'b11:   begin exp_half = 12'd1; exp_mod = 12'd4; end
            default: begin exp_half = 12'd2; exp_mod = 12'd4; end
        endcase
        exp_frame = exp_half * 12'd128;
    end

    // Measure run lengths and gaps between pulses.
    always_ff @(posedge mck) begin
        rst_low_q <= !rst_n;
        if (!rst_n) begin
            hi_run <= '0; lo_run <= '0; mod_gap <= '0; stb_gap <= '0;
            armed <= 1'b0; bck_d <= 1'b0; mod_seen <= 1'b0; stb_seen <= 1'b0;
        end else begin
            hi_run   <= bck ? hi_run + 12'd1 : '0;
            lo_run   <= bck ? '0 : lo_run + 12'd1;
            mod_gap  <= mod_en ? 12'd1 : mod_gap + 12'd1;
            stb_gap  <= smp_stb ? 12'd1 : stb_gap + 12'd1;
            bck_d    <= bck;
            armed    <= armed | (bck_d & !bck);
            mod_seen <= mod_seen | mod_en;
            stb_seen <= stb_seen | smp_stb;
        end
    end

    // R1: the edge after a sampled-low reset leaves every output low.
    always_ff @(posedge mck) begin
        if (rst_low_q) begin
            assert_reset_quiet_R1: assert (!bck && !lrck && !smp_stb && !mod_en)
                else $error("outputs not cleared by reset");
        end
    end

    // R3 R4: each high run of bck lasts exactly half a bit period.
    assert_bck_high_R4: assert property (@(posedge mck) disable iff (!rst_n)
        $fell(bck) |-> hi_run == exp_half);

    // R3 R4: each low run after the first fall lasts half a bit period.
    assert_bck_low_R4: assert property (@(posedge mck) disable iff (!rst_n)
        (armed && $rose(bck)) |-> lo_run == exp_half);

    // R5 R2: modulator enable spacing follows the mode captured at reset.
    assert_mod_gap_R5: assert property (@(posedge mck) disable iff (!rst_n)
        (mod_en && mod_seen) |-> mod_gap == exp_mod);

    // R6: the frame clock moves only together with a bck fall.
    assert_lrck_edge_R6: assert property (@(posedge mck) disable iff (!rst_n)
        (lrck != $past(lrck)) |-> $fell(bck));

    // R7: the strobe sits at the left-frame start with both clocks low.
    assert_stb_phase_R7: assert property (@(posedge mck) disable iff (!rst_n)
        smp_stb |-> (!lrck && !bck));

    // R7: the strobe lasts one cycle.
    assert_stb_single_R7: assert property (@(posedge mck) disable iff (!rst_n)
        smp_stb |=> !smp_stb);

    // R7: strobes are one frame apart.
    assert_stb_gap_R7: assert property (@(posedge mck) disable iff (!rst_n)
        (smp_stb && stb_seen) |-> stb_gap == exp_frame);

endmodule

bind adc_clk_timing actc_timing_chk u_chk (.*);

// File: tb/adc_clk_timing_test.sv
// Sweeps every mode over more than two frames and checks all outputs each
// cycle against an arithmetic model of phase t.
module adc_clk_timing_test;

    logic       mck = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       mod_en, bck, lrck, smp_stb;
    int         checks = 0;
    int         failures = 0;

    adc_clk_timing uut (
        .mck      (mck),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .mod_en   (mod_en),
        .bck      (bck),
        .lrck     (lrck),
        .smp_stb  (smp_stb)
    );

    always #5 mck = ~mck;

    function automatic int bit_div(int m);
        return (m == 1) ? 6 : (m == 3) ? 2 : 4;
    endfunction

    function automatic int mod_div(int m);
        return (m == 1) ? 6 : (m == 2) ? 8 : 4;
    endfunction

    task automatic chk(string req, string what, int t, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s t=%0d actual=%0b expected=%0b", req, what, t, act, exp);
        end
    endtask

    // Reset for three edges, run one mode, flip mode_sel midway.
    task automatic run_mode(int m, bit later_run);
        int d = bit_div(m);
        int md = mod_div(m);
        int cycles = 2 * 64 * d + 37;
        bit flipped = 1'b0;
        @(negedge mck);
        rst_n = 1'b0;
        mode_sel = 2'(m);
        for (int i = 0; i < 3; i++) begin
            @(posedge mck);
            @(negedge mck);
            chk("R1", "bck", i, bck, 1'b0);
            chk("R1", "lrck", i, lrck, 1'b0);
            chk("R1", "smp_stb", i, smp_stb, 1'b0);
            chk("R1", "mod_en", i, mod_en, 1'b0);
        end
        rst_n = 1'b1;
        for (int k = 1; k <= cycles; k++) begin
            int t = k - 1;
            string rb, rl, rs, rm;
            @(posedge mck);
            @(negedge mck);
            rb = "R4"; rl = "R6"; rs = "R7"; rm = "R5";
            if (t % d == 0) rb = "R3";
            if (later_run && t < 64 * d) begin rb = "R9"; rl = "R9"; rs = "R9"; rm = "R9"; end
            if (flipped) begin rb = "R2"; rm = "R2"; end
            if (k == 1) begin rb = "R8"; rl = "R8"; rs = "R8"; rm = "R8"; end
            chk(rb, "bck", t, bck, (t % d) >= d / 2);
            chk(rl, "lrck", t, lrck, ((t / d) % 64) >= 32);
            chk(rs, "smp_stb", t, smp_stb, (t % (64 * d)) == 0);
            chk(rm, "mod_en", t, mod_en, (t % md) == 0);
            if (k == cycles / 2) begin
                mode_sel = 2'(m ^ 2'b11);
                flipped = 1'b1;
            end
        end
    endtask

    initial begin
        run_mode(0, 1'b0);
        run_mode(1, 1'b1);
        run_mode(2, 1'b1);
        run_mode(3, 1'b1);
        run_mode(1, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule